// File: doc/BRIEF.md
# Slow-Clock Timekeeper with Trim and Compare

This block keeps time from a low-frequency oscillator of about 32 kHz. A trim prescaler divides the slow clock and feeds a 32-bit count that runs without stopping and wraps. A compare value raises an interrupt when the count advances onto it. Software can program the divider, preload the count and arm the compare for one-shot use. For one-shot use, the next event is the current count plus a delta.

The register port runs on the fast bus clock and the count runs on the slow clock. Each write to the divider, count or compare register goes to the slow side through its own transfer channel, a toggle-and-acknowledge handshake. Each channel has two states. XF_IDLE moves to XF_BUSY when a write is accepted. XF_BUSY moves back to XF_IDLE once the returned acknowledge equals the request. While a channel is in XF_BUSY, its pending flag is set and it ignores further writes.

The count reaches the bus side through a snapshot loop, which has two states. MR_ASK toggles a request and always moves to MR_WAIT. MR_WAIT captures the slow-side snapshot when the acknowledge matches and then returns to MR_ASK. A bus read therefore never sees a value that is half old and half new.

Top module: `slowtick_timer`

## Requirements
- R1: After reset, every register reads zero: control/status (address 0), trim (1), count (2), compare (3) and interrupt flag (4). The irq output is low, and the clock-seen bit stays 0 until the first slow-clock edge after reset.
- R2: Control/status bit 2 (clock seen) becomes 1 after a slow-clock edge and never returns to 0 until reset.
- R3: With trim value T (address 1, bits 15:0), the count advances once every T+1 slow-clock edges.
- R4: The count is 32 bits wide and wraps from 0xFFFFFFFF to 0.
- R5: Writing address 2 loads that value into the count. Reading address 2 returns the current count, a few slow cycles old at most, and never a mixed value.
- R6: A write to trim, count or compare sets that register's pending bit: control/status bit 3, 4 or 5. The bit stays set until the value has taken effect on the slow side. Writes to that register while its bit is set are ignored.
- R7: When the count advances onto the compare value, interrupt flag bit 0 (address 4) sets and irq goes high. Both stay set until bit 0 is written with 1. Writing 0 has no effect.
- R8: The count advances only while both control/status bit 0 (oscillator enable) and bit 1 (run enable) are 1. Otherwise it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset for both domains, active low |
| slow_clk_i | input | 1 | Slow oscillator clock |
| wr_en_i | input | 1 | Single-cycle write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Compare interrupt, level |

## Verification
The assertions take for granted that the slow clock period is many bus cycles long, so that each handshake edge is seen by the other side. They also assume that reset is held across at least one edge of each clock and that every write strobe lasts one bus cycle. The stimulus uses a slow clock ten times slower than the bus clock and drives single-cycle writes on the falling bus edge. Reset is held over a full slow period. Count results after enable windows are checked within a small tolerance that covers the synchroniser delay, while held counts are checked exactly.

// File: rtl/tk_pkg.sv
package tk_pkg;
    typedef enum logic {XF_IDLE, XF_BUSY} xf_state_e;
    typedef enum logic {MR_ASK, MR_WAIT} mr_state_e;

    localparam logic [2:0] A_CTL   = 3'd0;
    localparam logic [2:0] A_TRIM  = 3'd1;
    localparam logic [2:0] A_CNT   = 3'd2;
    localparam logic [2:0] A_MATCH = 3'd3;
    localparam logic [2:0] A_IRQ   = 3'd4;

    localparam int B_OSC    = 0;
    localparam int B_RUN    = 1;
    localparam int B_SEEN   = 2;
    localparam int B_PTRIM  = 3;
    localparam int B_PCNT   = 4;
    localparam int B_PMATCH = 5;
endpackage

// File: rtl/tk_sync.sv
module tk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= {sh_q[STAGES-2:0], d_i};
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/tk_prescale.sv
module tk_prescale #(
    parameter int TRIM_W = 16
) (
    input  logic              sclk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic              restart_i,
    input  logic [TRIM_W-1:0] trim_i,
    output logic              tick_o
);
    localparam logic [TRIM_W-1:0] STEP = {{(TRIM_W-1){1'b0}}, 1'b1};

    logic [TRIM_W-1:0] pre_q;
    logic              wrap;

    assign wrap = (pre_q >= trim_i);

    always_ff @(posedge sclk_i or negedge rst_ni) begin
        if (!rst_ni)        pre_q <= '0;
        else if (restart_i) pre_q <= '0;
        else if (en_i)      pre_q <= wrap ? '0 : pre_q + STEP;
    end

    assign tick_o = en_i && wrap && !restart_i;

    // R3: with a nonzero divider no two ticks are adjacent
    a_r3_tick_gap: assert property (@(posedge sclk_i) disable iff (!rst_ni)
        tick_o |=> (!tick_o || trim_i == '0));
endmodule

// File: rtl/tk_xfer.sv
module tk_xfer
    import tk_pkg::*;
#(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         bclk_i,
    input  logic         sclk_i,
    input  logic         rst_ni,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] hold_o,
    output logic         pend_o,
    output logic         load_o
);
    xf_state_e    state_q, state_d;
    logic         req_q, req_s, ack_q, ack_s;
    logic [W-1:0] hold_q;

    always_ff @(posedge bclk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= XF_IDLE;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XF_IDLE: if (wr_i)            state_d = XF_BUSY;
            XF_BUSY: if (ack_s == req_q)  state_d = XF_IDLE;
            default:                      state_d = XF_IDLE;
        endcase
    end

    always_ff @(posedge bclk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            hold_q <= '0;
            req_q  <= 1'b0;
        end else if (state_q == XF_IDLE && wr_i) begin
            hold_q <= wdata_i;
            req_q  <= ~req_q;
        end
    end

    always_ff @(posedge sclk_i or negedge rst_ni) begin
        if (!rst_ni) ack_q <= 1'b0;
        else         ack_q <= req_s;
    end

    tk_sync #(.STAGES(STAGES)) u_req (.clk_i(sclk_i), .rst_ni(rst_ni), .d_i(req_q), .q_o(req_s));
    tk_sync #(.STAGES(STAGES)) u_ack (.clk_i(bclk_i), .rst_ni(rst_ni), .d_i(ack_q), .q_o(ack_s));

    always_comb begin
        pend_o = (state_q == XF_BUSY);
        hold_o = hold_q;
        load_o = (req_s != ack_q);
    end

    // R6: a write arriving during a transfer leaves the held value alone
    a_r6_hold_stable: assert property (@(posedge bclk_i) disable iff (!rst_ni)
        (state_q == XF_BUSY) |=> $stable(hold_q));
    // R6: pending only rises because of a write
    a_r6_pend_from_write: assert property (@(posedge bclk_i) disable iff (!rst_ni)
        $rose(pend_o) |-> $past(wr_i));
endmodule

// File: rtl/tk_mirror.sv
module tk_mirror
    import tk_pkg::*;
#(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         bclk_i,
    input  logic         sclk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] sval_i,
    output logic [W-1:0] bval_o
);
    mr_state_e    state_q, state_d;
    logic         req_q, req_s, ack_q, ack_s;
    logic [W-1:0] snap_q, view_q;

    always_ff @(posedge bclk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= MR_ASK;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MR_ASK:  state_d = MR_WAIT;
            MR_WAIT: if (ack_s == req_q) state_d = MR_ASK;
            default: state_d = MR_ASK;
        endcase
    end

    always_ff @(posedge bclk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            req_q  <= 1'b0;
            view_q <= '0;
        end else if (state_q == MR_ASK) begin
            req_q <= ~req_q;
        end else if (ack_s == req_q) begin
            view_q <= snap_q;
        end
    end

    always_ff @(posedge sclk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ack_q  <= 1'b0;
            snap_q <= '0;
        end else if (req_s != ack_q) begin
            ack_q  <= req_s;
            snap_q <= sval_i;
        end
    end

    tk_sync #(.STAGES(STAGES)) u_req (.clk_i(sclk_i), .rst_ni(rst_ni), .d_i(req_q), .q_o(req_s));
    tk_sync #(.STAGES(STAGES)) u_ack (.clk_i(bclk_i), .rst_ni(rst_ni), .d_i(ack_q), .q_o(ack_s));

    always_comb bval_o = view_q;

    // R5: the snapshot is frozen while the bus side may capture it
    a_r5_snap_frozen: assert property (@(posedge sclk_i) disable iff (!rst_ni)
        (req_s == ack_q) |=> $stable(snap_q));
endmodule

// File: rtl/slowtick_timer.sv
module slowtick_timer
    import tk_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int TRIM_W = 16,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             slow_clk_i,
    input  logic             wr_en_i,
    input  logic [2:0]       addr_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] rdata_o,
    output logic             irq_o
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic wr_ctl, wr_trim, wr_cnt, wr_match, wr_irq;
    logic osc_en_q, run_en_q, irq_q, seen_q, seen_s;
    logic mt_s, mt_prev_q, match_edge;
    logic pend_trim, pend_cnt, pend_match;
    logic ld_trim, ld_cnt, ld_match;
    logic [TRIM_W-1:0] trim_hold, trim_s;
    logic [CNT_W-1:0]  cnt_hold, match_hold, match_s, count_q, count_view, cnt_inc;
    logic osc_s, run_s, adv, tick, alive_q, mt_tgl_q;

    // ---------------- bus domain ----------------
    always_comb begin
        wr_ctl   = wr_en_i && (addr_i == A_CTL);
        wr_trim  = wr_en_i && (addr_i == A_TRIM);
        wr_cnt   = wr_en_i && (addr_i == A_CNT);
        wr_match = wr_en_i && (addr_i == A_MATCH);
        wr_irq   = wr_en_i && (addr_i == A_IRQ);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            osc_en_q <= 1'b0;
            run_en_q <= 1'b0;
        end else if (wr_ctl) begin
            osc_en_q <= wdata_i[B_OSC];
            run_en_q <= wdata_i[B_RUN];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seen_q    <= 1'b0;
            mt_prev_q <= 1'b0;
            irq_q     <= 1'b0;
        end else begin
            seen_q    <= seen_q | seen_s;
            mt_prev_q <= mt_s;
            if (match_edge)                 irq_q <= 1'b1;
            else if (wr_irq && wdata_i[0])  irq_q <= 1'b0;
        end
    end

    assign match_edge = mt_s ^ mt_prev_q;

    tk_xfer #(.W(TRIM_W), .STAGES(STAGES)) u_x_trim (
        .bclk_i(clk_i), .sclk_i(slow_clk_i), .rst_ni(rst_ni), .wr_i(wr_trim),
        .wdata_i(wdata_i[TRIM_W-1:0]), .hold_o(trim_hold), .pend_o(pend_trim), .load_o(ld_trim));
    tk_xfer #(.W(CNT_W), .STAGES(STAGES)) u_x_cnt (
        .bclk_i(clk_i), .sclk_i(slow_clk_i), .rst_ni(rst_ni), .wr_i(wr_cnt),
        .wdata_i(wdata_i), .hold_o(cnt_hold), .pend_o(pend_cnt), .load_o(ld_cnt));
    tk_xfer #(.W(CNT_W), .STAGES(STAGES)) u_x_match (
        .bclk_i(clk_i), .sclk_i(slow_clk_i), .rst_ni(rst_ni), .wr_i(wr_match),
        .wdata_i(wdata_i), .hold_o(match_hold), .pend_o(pend_match), .load_o(ld_match));

    tk_mirror #(.W(CNT_W), .STAGES(STAGES)) u_view (
        .bclk_i(clk_i), .sclk_i(slow_clk_i), .rst_ni(rst_ni),
        .sval_i(count_q), .bval_o(count_view));

    tk_sync #(.STAGES(STAGES)) u_seen (.clk_i(clk_i), .rst_ni(rst_ni), .d_i(alive_q), .q_o(seen_s));
    tk_sync #(.STAGES(STAGES)) u_mt   (.clk_i(clk_i), .rst_ni(rst_ni), .d_i(mt_tgl_q), .q_o(mt_s));

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            A_CTL: begin
                rdata_o[B_OSC]    = osc_en_q;
                rdata_o[B_RUN]    = run_en_q;
                rdata_o[B_SEEN]   = seen_q;
                rdata_o[B_PTRIM]  = pend_trim;
                rdata_o[B_PCNT]   = pend_cnt;
                rdata_o[B_PMATCH] = pend_match;
            end
            A_TRIM:  rdata_o[TRIM_W-1:0] = trim_hold;
            A_CNT:   rdata_o = count_view;
            A_MATCH: rdata_o = match_hold;
            A_IRQ:   rdata_o[0] = irq_q;
            default: rdata_o = '0;
        endcase
    end

    assign irq_o = irq_q;

    // ---------------- slow domain ----------------
    tk_sync #(.STAGES(STAGES)) u_osc (.clk_i(slow_clk_i), .rst_ni(rst_ni), .d_i(osc_en_q), .q_o(osc_s));
    tk_sync #(.STAGES(STAGES)) u_run (.clk_i(slow_clk_i), .rst_ni(rst_ni), .d_i(run_en_q), .q_o(run_s));

    assign adv     = osc_s && run_s;
    assign cnt_inc = count_q + ONE;

    tk_prescale #(.TRIM_W(TRIM_W)) u_pre (
        .sclk_i(slow_clk_i), .rst_ni(rst_ni), .en_i(adv),
        .restart_i(ld_trim || ld_cnt), .trim_i(trim_s), .tick_o(tick));

    always_ff @(posedge slow_clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            alive_q  <= 1'b0;
            trim_s   <= '0;
            match_s  <= '0;
            count_q  <= '0;
            mt_tgl_q <= 1'b0;
        end else begin
            alive_q <= 1'b1;
            if (ld_trim)  trim_s  <= trim_hold;
            if (ld_match) match_s <= match_hold;
            if (ld_cnt)    count_q <= cnt_hold;
            else if (tick) count_q <= cnt_inc;
            if (tick && !ld_cnt && (cnt_inc == match_s)) mt_tgl_q <= ~mt_tgl_q;
        end
    end

    // R4: the count moves only on a prescaler tick or a load
    a_r4_count_moves: assert property (@(posedge slow_clk_i) disable iff (!rst_ni)
        (count_q != $past(count_q)) |-> $past(tick || ld_cnt));
    // R8: without both enables the count holds
    a_r8_hold_when_off: assert property (@(posedge slow_clk_i) disable iff (!rst_ni)
        (!adv && !ld_cnt) |=> $stable(count_q));
    // R7: the flag falls only after a write of 1 to bit 0
    a_r7_clear_by_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(irq_q) |-> $past(wr_irq && wdata_i[0]));
    // R2: clock-seen is sticky
    a_r2_seen_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$fell(seen_q));
endmodule

// File: tb/sim_slowtick_timer.sv
`timescale 1ns/1ps
module sim_slowtick_timer;
    logic        clk = 1'b0;
    logic        sclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic        irq;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #5  clk  = ~clk;
    always #50 sclk = ~sclk;

    slowtick_timer u0 (
        .clk_i(clk), .rst_ni(rst_n), .slow_clk_i(sclk), .wr_en_i(we),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

    localparam int NV = 5;
    localparam int VT[NV] = '{0, 1, 3, 15, 7};
    localparam int VW[NV] = '{200, 200, 200, 320, 160};
    localparam int VE[NV] = '{200, 100, 50, 20, 20};

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 500; i++) begin
            rd(3'd0, v);
            if (v[5:3] == 3'b000) return;
        end
        chk(1'b0, "R6 pending never cleared", v, 32'd0);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int d;
        idle(11);
        rst_n = 1'b1;

        // R1 reset state
        rd(3'd0, v); chk(v == 32'd0, "R1 ctl after reset", v, 32'd0);
        rd(3'd1, v); chk(v == 32'd0, "R1 trim after reset", v, 32'd0);
        rd(3'd2, v); chk(v == 32'd0, "R1 count after reset", v, 32'd0);
        rd(3'd3, v); chk(v == 32'd0, "R1 match after reset", v, 32'd0);
        rd(3'd4, v); chk(v == 32'd0 && irq == 1'b0, "R1 irq after reset", {v[30:0], irq}, 32'd0);

        // R2 clock seen
        idle(40);
        rd(3'd0, v); chk(v[2] == 1'b1, "R2 clock seen", v, 32'h4);
        idle(200);
        rd(3'd0, v); chk(v[2] == 1'b1, "R2 clock seen sticky", v, 32'h4);

        // R6 pending and ignored write
        wr(3'd1, 32'd5);
        rd(3'd0, v); chk(v[3] == 1'b1, "R6 trim pending", v, 32'h8);
        wr(3'd1, 32'd9);
        wait_idle();
        rd(3'd1, v); chk(v == 32'd5, "R6 write during pending ignored", v, 32'd5);
        wr(3'd2, 32'h1234ABCD);
        rd(3'd0, v); chk(v[4] == 1'b1, "R6 count pending", v, 32'h10);
        wait_idle();
        wr(3'd3, 32'd7);
        rd(3'd0, v); chk(v[5] == 1'b1, "R6 match pending", v, 32'h20);
        wait_idle();

        // R5 load, read back exact while stopped
        idle(80);
        rd(3'd2, v); chk(v == 32'h1234ABCD, "R5 loaded count", v, 32'h1234ABCD);
        // R8 oscillator off, run on: no advance
        wr(3'd0, 32'h2);
        idle(400);
        wr(3'd0, 32'h0);
        idle(80);
        rd(3'd2, v); chk(v == 32'h1234ABCD, "R8 hold without osc enable", v, 32'h1234ABCD);

        // R3 divider table
        for (int k = 0; k < NV; k++) begin
            wr(3'd0, 32'h1);
            wr(3'd1, VT[k]);
            wait_idle();
            wr(3'd2, 32'd0);
            wait_idle();
            idle(60);
            wr(3'd0, 32'h3);
            idle(VW[k] * 10);
            wr(3'd0, 32'h1);
            idle(80);
            rd(3'd2, v);
            d = int'(v) - VE[k];
            chk(d >= -2 && d <= 2, "R3 divide by trim+1", v, VE[k]);
        end

        // R4 wrap
        wr(3'd1, 32'd0);
        wait_idle();
        wr(3'd2, 32'hFFFFFFF0);
        wait_idle();
        idle(60);
        wr(3'd0, 32'h3);
        idle(400);
        wr(3'd0, 32'h1);
        idle(80);
        rd(3'd2, v);
        chk(v >= 32'd22 && v <= 32'd26, "R4 wrap to zero", v, 32'd24);

        // R7 compare interrupt
        wr(3'd2, 32'd100);
        wait_idle();
        wr(3'd3, 32'd130);
        wait_idle();
        wr(3'd4, 32'd1);
        rd(3'd4, v); chk(v == 32'd0 && irq == 1'b0, "R7 irq clear before run", v, 32'd0);
        idle(40);
        wr(3'd0, 32'h3);
        idle(100);
        rd(3'd4, v); chk(v == 32'd0 && irq == 1'b0, "R7 no irq before match", v, 32'd0);
        idle(400);
        rd(3'd4, v); chk(v == 32'd1 && irq == 1'b1, "R7 irq on match", v, 32'd1);
        wr(3'd4, 32'd0);
        rd(3'd4, v); chk(v == 32'd1 && irq == 1'b1, "R7 write 0 keeps flag", v, 32'd1);
        wr(3'd4, 32'd1);
        rd(3'd4, v); chk(v == 32'd0 && irq == 1'b0, "R7 write 1 clears", v, 32'd0);
        idle(200);
        rd(3'd4, v); chk(v == 32'd0 && irq == 1'b0, "R7 no retrigger past match", v, 32'd0);
        wr(3'd0, 32'h1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule